// File: doc/BRIEF.md
# Multi-lane deserializer with bit-slip word alignment

The block turns one serial bit stream per lane into parallel words of `FACTOR` bits. All lanes share one fast bit clock. The parallel word rate is a clock enable that fires once every `FACTOR` captured bits, so the parallel domain is derived from the fast clock and stays locked to it. Capture does not start until the clock source reports lock. Capture stops again as soon as lock drops.

Each lane has its own word boundary. A rising edge on the lane's slip input adds one bit of serial latency to that lane, which moves its word boundary by one position. The added latency counts modulo `ROLLOVER`. After `ROLLOVER` slips the lane is back at zero added latency. The slip input is sampled and edge-detected on the word-rate enable, so a level held high for any number of words counts as a single slip. The parallel output is registered by default; a parameter makes it combinational instead.

A small controller sequences capture through two states. `ST_WAIT` holds the bit counter at zero and captures nothing. `ST_RUN` captures one bit per clock while lock stays high. The transition `LOCK_SEEN` (`ST_WAIT` to `ST_RUN`) is taken on a clock edge at which lock is high. The transition `LOCK_LOST` (`ST_RUN` to `ST_WAIT`) is taken on an edge at which lock is low. Reset forces `ST_WAIT`.

Top module: `bitslip_deser`

## Requirements
- R1: Each lane L delivers its word on `word_o[L*FACTOR +: FACTOR]`. The first bit received for a word sits in the most significant bit of that field.
- R2: No bit is captured and `word_vld_o` stays low while in `ST_WAIT`. The first captured bit is the one present at the clock edge after the edge that sampled `lock_i` high.
- R3: `word_vld_o` is high for exactly one cycle per `FACTOR` captured bits.
- R4: A rising edge on `slip_i[L]`, held for at least one word, adds exactly one bit of latency to lane L only. For a stream that repeats a `FACTOR`-bit pattern P, the lane then outputs P rotated right by its slip count. The change appears on a later word, and no word is ever shortened.
- R5: A slip level held high across many words counts as one slip.
- R6: After `ROLLOVER` slips (default 4), the lane returns to zero added latency and outputs P unrotated again. The slip count never reaches `ROLLOVER`.
- R7: Slips on one lane leave the other lanes' alignment unchanged.
- R8: With `REG_OUT`=1 (default), the word and `word_vld_o` appear one cycle after the edge that captured the word's last bit. With `REG_OUT`=0, the same word and strobe are presented combinationally during the cycle of that edge.
- R9: Synchronous reset clears the slip counts, the bit counter, the output word and the strobe.
- R10: Loss of lock returns to `ST_WAIT` and clears the bit counter, so that after lock returns, words are framed from the first new bit. The slip counts are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_i | input | 1 | Clock source locked; gates capture |
| ser_i | input | LANES | Serial data, one bit per lane |
| slip_i | input | LANES | Per-lane bit-slip request, edge sensitive |
| word_o | output | LANES*FACTOR | Parallel words, lane 0 in the low field |
| word_vld_o | output | 1 | One-cycle strobe per parallel word |

## Verification
Some properties are checked on every cycle:
- each slip count stays below the rollover limit;
- a slip count changes only on a word-rate enable, and only by one step with wrap;
- the strobe never lasts two cycles and never follows a cycle without lock;
- reset clears counts and strobe.

Other behaviour is shown only by bench scenarios, using a repeating known pattern:
- the rotated data after each slip;
- the return to the original alignment after the rollover count;
- lane independence;
- the single count for a held slip level;
- reframing after a lock loss;
- the one-cycle offset between the registered and combinational variants.

// File: rtl/bitslip_deser_pkg.sv
`timescale 1ns/1ps
package bitslip_deser_pkg;

    // Capture sequencing states
    typedef enum logic {
        ST_WAIT = 1'b0,  // no lock: bit counter held, nothing captured
        ST_RUN  = 1'b1   // capturing one bit per clock
    } deser_state_t;

    // Width of a counter able to hold values 0..n-1 (at least one bit)
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bitslip_deser_ctrl.sv
`timescale 1ns/1ps
module bitslip_deser_ctrl
    import bitslip_deser_pkg::*;
#(
    parameter int FACTOR = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lock_i,
    output logic         shift_en,
    output logic         tick,
    output deser_state_t state
);
    localparam int CW = cnt_width(FACTOR);
    localparam logic [CW-1:0] LAST_BIT = CW'(FACTOR - 1);

    deser_state_t st_nxt;
    logic [CW-1:0] bcnt;

    // next-state logic: LOCK_SEEN and LOCK_LOST
    always_comb begin
        st_nxt = state;
        unique case (state)
            ST_WAIT: if (lock_i)  st_nxt = ST_RUN;   // LOCK_SEEN
            ST_RUN:  if (!lock_i) st_nxt = ST_WAIT;  // LOCK_LOST
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT;
        else     state <= st_nxt;
    end

    // outputs of the state machine
    always_comb begin
        shift_en = 1'b0;
        unique case (state)
            ST_WAIT: shift_en = 1'b0;
            ST_RUN:  shift_en = lock_i;
        endcase
        tick = shift_en && (bcnt == LAST_BIT);
    end

    // bit position inside the current word
    always_ff @(posedge clk) begin
        if (rst || !shift_en)  bcnt <= '0;
        else if (bcnt == LAST_BIT) bcnt <= '0;
        else                   bcnt <= bcnt + 1'b1;
    end

endmodule

// File: rtl/bitslip_deser_slip.sv
`timescale 1ns/1ps
module bitslip_deser_slip
    import bitslip_deser_pkg::*;
#(
    parameter int ROLLOVER = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic                          slip_i,
    output logic [cnt_width(ROLLOVER)-1:0] ofs
);
    localparam int SW = cnt_width(ROLLOVER);
    localparam logic [SW-1:0] OFS_MAX = SW'(ROLLOVER - 1);

    logic slip_meta, slip_sync, slip_prev;
    logic slip_edge;

    // sampled in the word-rate domain; edge seen once per level rise
    always_ff @(posedge clk) begin
        if (rst) begin
            slip_meta <= 1'b0;
            slip_sync <= 1'b0;
            slip_prev <= 1'b0;
        end else if (tick) begin
            slip_meta <= slip_i;
            slip_sync <= slip_meta;
            slip_prev <= slip_sync;
        end
    end

    assign slip_edge = tick && slip_sync && !slip_prev;

    // added serial latency, wraps to zero after ROLLOVER slips
    always_ff @(posedge clk) begin
        if (rst)            ofs <= '0;
        else if (slip_edge) ofs <= (ofs == OFS_MAX) ? '0 : ofs + 1'b1;
    end

endmodule

// File: rtl/bitslip_deser_lane.sv
`timescale 1ns/1ps
module bitslip_deser_lane
    import bitslip_deser_pkg::*;
#(
    parameter int FACTOR   = 8,
    parameter int ROLLOVER = 4,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           shift_en,
    input  logic                           tick,
    input  logic                           ser_i,
    input  logic [cnt_width(ROLLOVER)-1:0] ofs,
    output logic [FACTOR-1:0]              word_o
);
    localparam int W = FACTOR + ROLLOVER - 1;

    logic [W-1:0]      sh;
    logic [W-1:0]      sh_nxt;
    logic [FACTOR-1:0] word_sel;

    generate
        if (W == 1) begin : g_one
            assign sh_nxt = ser_i;
        end else begin : g_many
            assign sh_nxt = {sh[W-2:0], ser_i};
        end
    endgenerate

    // newest bit in position 0; older bits move upward
    always_ff @(posedge clk) begin
        if (rst)           sh <= '0;
        else if (shift_en) sh <= sh_nxt;
    end

    // window delayed by ofs bits; oldest bit lands in the MSB
    assign word_sel = sh_nxt[ofs +: FACTOR];

    generate
        if (REG_OUT) begin : g_reg
            logic [FACTOR-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst)       word_q <= '0;
                else if (tick) word_q <= word_sel;
            end
            assign word_o = word_q;
        end else begin : g_comb
            assign word_o = word_sel;
        end
    endgenerate

endmodule

// File: rtl/bitslip_deser.sv
`timescale 1ns/1ps
module bitslip_deser
    import bitslip_deser_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int FACTOR   = 8,
    parameter int ROLLOVER = 4,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lock_i,
    input  logic [LANES-1:0]         ser_i,
    input  logic [LANES-1:0]         slip_i,
    output logic [LANES*FACTOR-1:0]  word_o,
    output logic                     word_vld_o
);
    localparam int SW = cnt_width(ROLLOVER);

    logic              shift_en_w;
    logic              tick_w;
    deser_state_t      st_w;
    logic [LANES*SW-1:0] ofs_all;

    bitslip_deser_ctrl #(.FACTOR(FACTOR)) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .lock_i   (lock_i),
        .shift_en (shift_en_w),
        .tick     (tick_w),
        .state    (st_w)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            bitslip_deser_slip #(.ROLLOVER(ROLLOVER)) i_slip (
                .clk    (clk),
                .rst    (rst),
                .tick   (tick_w),
                .slip_i (slip_i[l]),
                .ofs    (ofs_all[l*SW +: SW])
            );
            bitslip_deser_lane #(
                .FACTOR   (FACTOR),
                .ROLLOVER (ROLLOVER),
                .REG_OUT  (REG_OUT)
            ) i_lane (
                .clk      (clk),
                .rst      (rst),
                .shift_en (shift_en_w),
                .tick     (tick_w),
                .ser_i    (ser_i[l]),
                .ofs      (ofs_all[l*SW +: SW]),
                .word_o   (word_o[l*FACTOR +: FACTOR])
            );
        end

        if (REG_OUT) begin : g_vld_reg
            logic vld_q;
            always_ff @(posedge clk) begin
                if (rst) vld_q <= 1'b0;
                else     vld_q <= tick_w;
            end
            assign word_vld_o = vld_q;
        end else begin : g_vld_comb
            assign word_vld_o = tick_w;
        end
    endgenerate

endmodule

// File: rtl/bitslip_deser_chk.sv
`timescale 1ns/1ps
module bitslip_deser_chk #(
    parameter int LANES    = 2,
    parameter int FACTOR   = 8,
    parameter int ROLLOVER = 4,
    parameter bit REG_OUT  = 1'b1,
    parameter int SW       = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                lock_i,
    input logic                word_vld_o,
    input logic                tick,
    input logic [LANES*SW-1:0] ofs_all
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_ofs
            // R6: slip count stays below the rollover limit
            a_r6_ofs_below_rollover: assert property (@(posedge clk) disable iff (rst)
                int'(ofs_all[l*SW +: SW]) < ROLLOVER);

            // R4: count moves only on a word enable, one step, with wrap
            a_r4_ofs_single_step: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$stable(ofs_all[l*SW +: SW])) |->
                    ($past(tick) &&
                     (int'(ofs_all[l*SW +: SW]) ==
                      ((int'($past(ofs_all[l*SW +: SW])) + 1) % ROLLOVER))));
        end

        if (FACTOR > 1) begin : g_pulse
            // R3: strobe lasts a single cycle
            a_r3_vld_single: assert property (@(posedge clk) disable iff (rst)
                word_vld_o |=> !word_vld_o);
        end

        if (REG_OUT) begin : g_lockreg
            // R2: a registered strobe only follows a locked cycle
            a_r2_vld_needs_lock: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && word_vld_o) |-> $past(lock_i));
        end else begin : g_lockcomb
            // R2: a combinational strobe only while locked
            a_r2_vld_needs_lock: assert property (@(posedge clk) disable iff (rst)
                word_vld_o |-> lock_i);
        end
    endgenerate

    // R9: reset clears slip counts and strobe
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (ofs_all == '0) && (!REG_OUT || !word_vld_o));

endmodule

bind bitslip_deser bitslip_deser_chk #(
    .LANES    (LANES),
    .FACTOR   (FACTOR),
    .ROLLOVER (ROLLOVER),
    .REG_OUT  (REG_OUT),
    .SW       (SW)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .lock_i     (lock_i),
    .word_vld_o (word_vld_o),
    .tick       (tick_w),
    .ofs_all    (ofs_all)
);

// File: tb/test_bitslip_deser.sv
`timescale 1ns/1ps
module test_bitslip_deser;
    localparam int LANES = 2;
    localparam int F     = 8;
    localparam int ROLL  = 4;
    localparam logic [7:0] P0 = 8'hCA;
    localparam logic [7:0] P1 = 8'h71;

    // vector: {slip lane0, slip lane1, expected rot lane0 [7:4], expected rot lane1 [3:0]}
    localparam int NV = 6;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd1, 4'd0},
        {1'b1, 1'b1, 4'd2, 4'd1},
        {1'b1, 1'b0, 4'd3, 4'd1},
        {1'b1, 1'b1, 4'd0, 4'd2},   // lane0 wraps (R6)
        {1'b0, 1'b1, 4'd0, 4'd3},
        {1'b0, 1'b1, 4'd0, 4'd0}    // lane1 wraps (R6)
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_i = 1'b0;
    logic [LANES-1:0] ser_i = '0;
    logic [LANES-1:0] slip_i = '0;
    logic [LANES*F-1:0] word_o, word_c;
    logic word_vld_o, vld_c;

    int n_chk = 0, n_fail = 0;
    int nwords = 0, comb_hits = 0, comb_bad = 0, cyc = 0, comb_cyc = -10;
    logic [LANES*F-1:0] last_word = '0, comb_word = '0;

    always #2.5 clk = ~clk;   // 200 MHz
    always @(posedge clk) cyc <= cyc + 1;

    bitslip_deser #(.LANES(LANES), .FACTOR(F), .ROLLOVER(ROLL), .REG_OUT(1'b1)) i_bitslip_deser (
        .clk(clk), .rst(rst), .lock_i(lock_i), .ser_i(ser_i), .slip_i(slip_i),
        .word_o(word_o), .word_vld_o(word_vld_o));

    bitslip_deser #(.LANES(LANES), .FACTOR(F), .ROLLOVER(ROLL), .REG_OUT(1'b0)) i_bitslip_deser_comb (
        .clk(clk), .rst(rst), .lock_i(lock_i), .ser_i(ser_i), .slip_i(slip_i),
        .word_o(word_c), .word_vld_o(vld_c));

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (word_vld_o) begin
            last_word = word_o;
            nwords++;
            if (!(cyc == comb_cyc + 1 && word_o == comb_word)) comb_bad++;
        end
        #1;
        if (vld_c) begin
            comb_word = word_c;
            comb_cyc = cyc;
            comb_hits++;
        end
    end

    function automatic logic [7:0] rotr(input logic [7:0] p, input int n);
        int k;
        k = n % 8;
        return (p >> k) | (p << (8 - k));
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [7:0] a, input logic [7:0] b);
        for (int i = F - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_i = {b[i], a[i]};
        end
    endtask

    task automatic send_n(input int n);
        repeat (n) send_word(P0, P1);
    endtask

    task automatic check_words(input string req, input int r0, input int r1);
        #1;
        check(last_word[7:0] == rotr(P0, r0), req, last_word[7:0], rotr(P0, r0));
        check(last_word[15:8] == rotr(P1, r1), req, last_word[15:8], rotr(P1, r1));
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(word_o == '0 && !word_vld_o, "R9 reset state", word_o, 0);
        @(negedge clk) rst = 1'b0;
        // R2: toggling data without lock gives no words
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ser_i = ser_i ^ 2'b11;
        end
        #1;
        check(nwords == 0 && comb_hits == 0, "R2 no words before lock", nwords, 0);
        @(negedge clk) lock_i = 1'b1;
        send_n(4);
        check_words("R1 R2 first alignment", 0, 0);

        // R3: one strobe per word
        n0 = nwords;
        send_n(10);
        #1;
        check(nwords - n0 == 10, "R3 strobe count", nwords - n0, 10);

        // R4 R6 R7: vector table
        for (int v = 0; v < NV; v++) begin
            slip_i = {VEC[v][8], VEC[v][9]};
            send_n(3);
            slip_i = '0;
            send_n(4);
            check_words("R4 R6 R7 slip vector", int'(VEC[v][7:4]), int'(VEC[v][3:0]));
        end

        // R5: long slip level counts once
        slip_i = 2'b01;
        send_n(6);
        check_words("R5 held slip", 1, 0);
        send_n(6);
        check_words("R5 held slip still one", 1, 0);
        slip_i = '0;
        send_n(4);

        // R10: lock lost mid-word, then regained
        for (int i = 7; i >= 5; i--) begin
            @(negedge clk);
            ser_i = {P1[i], P0[i]};
        end
        @(negedge clk) lock_i = 1'b0;
        repeat (3) @(negedge clk);
        #1 n0 = nwords;
        repeat (20) @(negedge clk) ser_i = ser_i ^ 2'b01;
        #1;
        check(nwords == n0, "R10 no words while unlocked", nwords - n0, 0);
        @(negedge clk) lock_i = 1'b1;
        send_n(4);
        check_words("R10 reframed after relock", 1, 0);

        // R8: combinational variant leads registered by one cycle
        #1;
        check(comb_bad == 0 && comb_hits > 0, "R8 registered vs combinational", comb_bad, 0);

        // R9: mid-run reset clears output and slip count
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        #1;
        check(word_o == '0 && !word_vld_o, "R9 reset clears output", word_o, 0);
        @(negedge clk) rst = 1'b0;
        send_n(4);
        check_words("R9 slip count cleared", 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule